// File: doc/BRIEF.md
# Audio Serial Port Register and FIFO Front End

This block is the register-side half of a stereo audio serial port. A host CPU or DMA engine sees a 32-bit register bus. Through it, software sets the link and format options and programs the FIFO trigger levels, an interrupt mask and a bit-clock divisor. One shared data address carries the sample stream. Writes to it fill a 16-entry transmit FIFO, and reads from it drain a 16-entry receive FIFO. The serializer sits on the other side of both FIFOs and uses a plain push/pop handshake.

The block raises a service request for each FIFO when its fill level crosses the programmed level, so the host knows when to refill or empty it. Two error conditions are kept as sticky flags: the serializer pushing into a full receive FIFO, and the serializer pulling from an empty transmit FIFO. Software clears each flag by writing a one to a separate clear register. The masked conditions are ORed onto a single interrupt line. A self-clearing soft-reset bit in the control register puts the whole block back to its power-on state.

Top module: `aud_serial_port`

## Requirements
- R1: After rst_n is low at a clock edge, every register reads 0 except status, which reads 0x81, and irq is low.
- R2: Control at 0x00 keeps the receive level in bits 15:12, the transmit level in bits 11:8, the special-function FIFO select in bit 5, the special-function enable in bit 4, the bit-clock direction in bit 2 and the link enable in bit 0. All other bits read 0. Format at 0x04 keeps only bits 5, 4, 3 and 0. Mask at 0x14 keeps bits 6..3. Divider at 0x60 keeps the low DIV_W bits. The matching output pins follow the stored values.
- R3: A write to 0x80 pushes the transmit FIFO. ser_tx_data shows the oldest entry, and each ser_tx_pop advances in order. A write to a full transmit FIFO is discarded.
- R4: ser_rx_push stores ser_rx_data. A read of 0x80 returns the oldest entry and removes it. A read of 0x80 with the receive FIFO empty returns 0 and changes nothing.
- R5: Status bit 3 is 1 when the link is enabled and the transmit fill is at or below the transmit level. Status bit 4 is 1 when the link is enabled and the receive fill is at or above the receive level.
- R6: A serializer push into a full receive FIFO with no bus pop in the same cycle drops the sample and sets sticky status bit 6. A push and a bus pop together at full both take effect and leave the flag unchanged.
- R7: A serializer pop of an empty transmit FIFO presents 0 on ser_tx_data and sets sticky status bit 5. A bus push in the same cycle is still stored.
- R8: Writing 1 to bit 6 or bit 5 of 0x18 clears the receive-overrun or transmit-underrun flag. Other bits have no effect. A new error in the same cycle keeps its flag set.
- R9: irq is the OR of status bits 6, 5, 4 and 3, each ANDed with the mask bit in the same position.
- R10: A write to 0x00 with bit 3 set empties both FIFOs and clears the flags and all registers by the next cycle. The other fields of that write are discarded.
- R11: Status bit 7 is 1 while the link is disabled. Bit 2 is 1 while the link is enabled and the transmit FIFO is not empty. Bit 1 is 1 while the receive FIFO is not empty. Bit 0 is 1 while the transmit FIFO is not full.
- R12: Reads of unmapped addresses return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x80) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| ser_tx_pop | input | 1 | Serializer takes one transmit word |
| ser_tx_data | output | DATA_W | Oldest transmit word, 0 when empty |
| ser_rx_push | input | 1 | Serializer delivers one receive word |
| ser_rx_data | input | DATA_W | Receive word |
| link_en | output | 1 | Link enable |
| bclk_master | output | 1 | Bit-clock direction |
| spec_en | output | 1 | Special-function enable |
| spec_sel | output | 1 | Special-function FIFO select |
| fmt_ctl | output | 6 | Stored format bits |
| clk_div | output | DIV_W | Bit-clock divisor |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of events can fall in the same cycle. In the first, the host pops the receive FIFO at the data address while the serializer pushes a sample into that FIFO when it is full. The bench sets up this case by filling the FIFO to 16, clearing the overrun flag, and then asserting both strobes on one edge. It passes only if the popped word is the oldest one, the new word appears last when the FIFO is drained, and the overrun flag stays clear. In the second, the serializer pops an empty transmit FIFO in the same cycle as a host write to that FIFO, or in the same cycle as a write-one-to-clear of the underrun flag. The bench checks that the written word is kept and that the flag stays set.

// File: rtl/aud_port_pkg.sv
// Package: address map, bit positions and control field layout of the
// audio serial port front end. Assumes an 8-bit byte address space.
package aud_port_pkg;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_FMT  = 8'h04;
    localparam logic [7:0] OFF_STAT = 8'h0C;
    localparam logic [7:0] OFF_MASK = 8'h14;
    localparam logic [7:0] OFF_CLR  = 8'h18;
    localparam logic [7:0] OFF_DIV  = 8'h60;
    localparam logic [7:0] OFF_DATA = 8'h80;

    localparam int C_EN    = 0;
    localparam int C_BCLK  = 2;
    localparam int C_SRST  = 3;
    localparam int C_SPEN  = 4;
    localparam int C_SPSEL = 5;
    localparam int C_TXTH  = 8;
    localparam int C_RXTH  = 12;
    localparam int TH_W    = 4;

    localparam int S_OFF = 7;
    localparam int S_ROR = 6;
    localparam int S_TUR = 5;
    localparam int S_RFS = 4;
    localparam int S_TFS = 3;
    localparam int S_BSY = 2;
    localparam int S_RNE = 1;
    localparam int S_TNF = 0;

    localparam int MASK_LSB = S_TFS;
    localparam int MASK_W   = 4;

    localparam logic [5:0] FMT_KEEP = 6'b111001;

    typedef struct packed {
        logic [TH_W-1:0] rx_th;
        logic [TH_W-1:0] tx_th;
        logic            sp_sel;
        logic            sp_en;
        logic            bclk_master;
        logic            link_en;
    } ctrl_t;

endpackage

// File: rtl/aud_fifo.sv
// Module: aud_fifo
// Synchronous FIFO with occupancy count and a synchronous flush.
// A pop of an empty FIFO is ignored. A push into a full FIFO is taken only
// when a pop happens in the same cycle. head reads 0 when the FIFO is empty.
// Assumes DEPTH >= 2.
module aud_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic                            push,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            pop,
    output logic [DATA_W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0]      count,
    output logic                            full,
    output logic                            empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop & ~empty;
    assign do_push = push & (~full | do_pop);
    assign head    = empty ? '0 : mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/aud_status.sv
// Module: aud_status
// Keeps the sticky overrun and underrun flags, compares the FIFO fill
// levels against the programmed levels, and builds the masked interrupt.
// A new error event wins over a same-cycle clear. Flush wins over both.
module aud_status #(
    parameter int CNT_W = 5,
    parameter int TH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             link_en,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [TH_W-1:0]  tx_th,
    input  logic [TH_W-1:0]  rx_th,
    input  logic             ovr_evt,
    input  logic             und_evt,
    input  logic             clr_ovr,
    input  logic             clr_und,
    input  logic [3:0]       irq_mask,
    output logic             ovr_flag,
    output logic             und_flag,
    output logic             tx_req,
    output logic             rx_req,
    output logic             irq
);
    localparam int CMP_W = (CNT_W > TH_W) ? CNT_W : TH_W;

    logic [CMP_W-1:0] tx_cnt_x, rx_cnt_x, tx_th_x, rx_th_x;

    assign tx_cnt_x = CMP_W'(tx_cnt);
    assign rx_cnt_x = CMP_W'(rx_cnt);
    assign tx_th_x  = CMP_W'(tx_th);
    assign rx_th_x  = CMP_W'(rx_th);

    assign tx_req = link_en & (tx_cnt_x <= tx_th_x);
    assign rx_req = link_en & (rx_cnt_x >= rx_th_x);

    // Sticky error flags: set by events, cleared by write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ovr_flag <= 1'b0;
            und_flag <= 1'b0;
        end else begin
            ovr_flag <= ovr_evt | (ovr_flag & ~clr_ovr);
            und_flag <= und_evt | (und_flag & ~clr_und);
        end
    end

    // Interrupt: any enabled condition, mask order {ovr, und, rx, tx}.
    always_comb begin
        irq = |({ovr_flag, und_flag, rx_req, tx_req} & irq_mask);
    end

endmodule

// File: rtl/aud_serial_port.sv
// Module: aud_serial_port
// Register and FIFO front end of a stereo audio serial port. Decodes a
// simple register bus, holds control, format, mask and divider registers,
// owns the transmit and receive FIFOs and reports status and interrupt.
// Assumes bus_rd and bus_wr are single-cycle strobes, and that read data
// is taken combinationally in the strobe cycle.
module aud_serial_port
    import aud_port_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ser_tx_pop,
    output logic [DATA_W-1:0] ser_tx_data,
    input  logic              ser_rx_push,
    input  logic [DATA_W-1:0] ser_rx_data,
    output logic              link_en,
    output logic              bclk_master,
    output logic              spec_en,
    output logic              spec_sel,
    output logic [5:0]        fmt_ctl,
    output logic [DIV_W-1:0]  clk_div,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    ctrl_t              ctrl_q;
    logic [5:0]         fmt_q;
    logic [MASK_W-1:0]  mask_q;
    logic [DIV_W-1:0]   div_q;

    logic hit_ctrl, hit_fmt, hit_stat, hit_mask, hit_clr, hit_div, hit_data;
    logic soft_rst;

    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              rx_pop_req;
    logic              ovr_evt, und_evt;
    logic              ovr_flag, und_flag, tx_req, rx_req;
    logic [7:0]        stat_vec;

    // Address decode of the register map.
    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_fmt  = (bus_addr == ADDR_W'(OFF_FMT));
        hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
        hit_mask = (bus_addr == ADDR_W'(OFF_MASK));
        hit_clr  = (bus_addr == ADDR_W'(OFF_CLR));
        hit_div  = (bus_addr == ADDR_W'(OFF_DIV));
        hit_data = (bus_addr == ADDR_W'(OFF_DATA));
    end

    assign soft_rst = bus_wr & hit_ctrl & bus_wdata[C_SRST];

    // Control register; the reset bit itself is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= '0;
        end else if (bus_wr && hit_ctrl) begin
            ctrl_q.rx_th       <= bus_wdata[C_RXTH +: TH_W];
            ctrl_q.tx_th       <= bus_wdata[C_TXTH +: TH_W];
            ctrl_q.sp_sel      <= bus_wdata[C_SPSEL];
            ctrl_q.sp_en       <= bus_wdata[C_SPEN];
            ctrl_q.bclk_master <= bus_wdata[C_BCLK];
            ctrl_q.link_en     <= bus_wdata[C_EN];
        end
    end

    // Format, interrupt mask and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            fmt_q  <= '0;
            mask_q <= '0;
            div_q  <= '0;
        end else if (bus_wr) begin
            if (hit_fmt) begin
                fmt_q <= bus_wdata[5:0] & FMT_KEEP;
            end
            if (hit_mask) begin
                mask_q <= bus_wdata[MASK_LSB +: MASK_W];
            end
            if (hit_div) begin
                div_q <= bus_wdata[DIV_W-1:0];
            end
        end
    end

    assign rx_pop_req = bus_rd & hit_data;
    assign und_evt    = ser_tx_pop & tx_empty;
    assign ovr_evt    = ser_rx_push & rx_full & ~rx_pop_req;

    aud_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) i_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst),
        .push  (bus_wr & hit_data),
        .wdata (bus_wdata),
        .pop   (ser_tx_pop),
        .head  (ser_tx_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    aud_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) i_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst),
        .push  (ser_rx_push),
        .wdata (ser_rx_data),
        .pop   (rx_pop_req),
        .head  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    aud_status #(
        .CNT_W (CNT_W),
        .TH_W  (TH_W)
    ) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (soft_rst),
        .link_en  (ctrl_q.link_en),
        .tx_cnt   (tx_cnt),
        .rx_cnt   (rx_cnt),
        .tx_th    (ctrl_q.tx_th),
        .rx_th    (ctrl_q.rx_th),
        .ovr_evt  (ovr_evt),
        .und_evt  (und_evt),
        .clr_ovr  (bus_wr & hit_clr & bus_wdata[S_ROR]),
        .clr_und  (bus_wr & hit_clr & bus_wdata[S_TUR]),
        .irq_mask (mask_q),
        .ovr_flag (ovr_flag),
        .und_flag (und_flag),
        .tx_req   (tx_req),
        .rx_req   (rx_req),
        .irq      (irq)
    );

    // Assemble the status byte.
    always_comb begin
        stat_vec        = '0;
        stat_vec[S_OFF] = ~ctrl_q.link_en;
        stat_vec[S_ROR] = ovr_flag;
        stat_vec[S_TUR] = und_flag;
        stat_vec[S_RFS] = rx_req;
        stat_vec[S_TFS] = tx_req;
        stat_vec[S_BSY] = ctrl_q.link_en & ~tx_empty;
        stat_vec[S_RNE] = ~rx_empty;
        stat_vec[S_TNF] = ~tx_full;
    end

    // Read data multiplexer; unmapped and clear addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[C_RXTH +: TH_W] = ctrl_q.rx_th;
            bus_rdata[C_TXTH +: TH_W] = ctrl_q.tx_th;
            bus_rdata[C_SPSEL]        = ctrl_q.sp_sel;
            bus_rdata[C_SPEN]         = ctrl_q.sp_en;
            bus_rdata[C_BCLK]         = ctrl_q.bclk_master;
            bus_rdata[C_EN]           = ctrl_q.link_en;
        end else if (hit_fmt) begin
            bus_rdata[5:0] = fmt_q;
        end else if (hit_stat) begin
            bus_rdata[7:0] = stat_vec;
        end else if (hit_mask) begin
            bus_rdata[MASK_LSB +: MASK_W] = mask_q;
        end else if (hit_div) begin
            bus_rdata[DIV_W-1:0] = div_q;
        end else if (hit_data) begin
            bus_rdata = rx_head;
        end
    end

    assign link_en     = ctrl_q.link_en;
    assign bclk_master = ctrl_q.bclk_master;
    assign spec_en     = ctrl_q.sp_en;
    assign spec_sel    = ctrl_q.sp_sel;
    assign fmt_ctl     = fmt_q;
    assign clk_div     = div_q;

endmodule

// File: rtl/aud_port_chk.sv
// Module: aud_port_chk
// Property checker bound into aud_serial_port. It watches bus strobes,
// serializer strobes, FIFO levels, sticky flags and the interrupt.
module aud_port_chk
    import aud_port_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ser_tx_pop,
    input logic [DATA_W-1:0] ser_tx_data,
    input logic              ser_rx_push,
    input logic              irq,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              tx_empty,
    input logic              rx_empty,
    input logic              rx_full,
    input logic              ovr_flag,
    input logic              und_flag,
    input logic [3:0]        mask_q
);
    logic data_rd, srst_wr, clr_ror_wr;

    assign data_rd    = bus_rd & (bus_addr == ADDR_W'(OFF_DATA));
    assign srst_wr    = bus_wr & (bus_addr == ADDR_W'(OFF_CTRL)) & bus_wdata[C_SRST];
    assign clr_ror_wr = bus_wr & (bus_addr == ADDR_W'(OFF_CLR)) & bus_wdata[S_ROR];

    // R3
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(FIFO_DEPTH));

    // R4
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(FIFO_DEPTH));

    // R4
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_empty) |-> (bus_rdata == '0));

    // R4
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_empty && !ser_rx_push) |=> rx_empty);

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_full && !data_rd && !srst_wr) |=> ovr_flag);

    // R6
    ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_full && !data_rd && !srst_wr) |=> rx_full);

    // R7
    und_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_pop && tx_empty) |-> (ser_tx_data == '0));

    // R7
    und_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_pop && tx_empty && !srst_wr) |=> und_flag);

    // R8
    w1c_ror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ror_wr && !ser_rx_push) |=> !ovr_flag);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'b0000) |-> !irq);

    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (tx_empty && rx_empty && !ovr_flag && !und_flag && mask_q == 4'b0000));

endmodule

bind aud_serial_port aud_port_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ser_tx_pop  (ser_tx_pop),
    .ser_tx_data (ser_tx_data),
    .ser_rx_push (ser_rx_push),
    .irq         (irq),
    .tx_cnt      (tx_cnt),
    .rx_cnt      (rx_cnt),
    .tx_empty    (tx_empty),
    .rx_empty    (rx_empty),
    .rx_full     (rx_full),
    .ovr_flag    (ovr_flag),
    .und_flag    (und_flag),
    .mask_q      (mask_q)
);

// File: tb/test_aud_serial_port.sv
// Scoreboard bench for aud_serial_port. Driver tasks queue the words they
// send into each FIFO, and monitor tasks pop and compare them as the design
// hands them out. Inputs change on the falling edge; outputs are sampled
// one time unit after it.
module test_aud_serial_port;
    localparam int CLK_P = 10;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_FMT  = 8'h04;
    localparam logic [7:0] A_STAT = 8'h0C;
    localparam logic [7:0] A_MASK = 8'h14;
    localparam logic [7:0] A_CLR  = 8'h18;
    localparam logic [7:0] A_DIV  = 8'h60;
    localparam logic [7:0] A_DATA = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_tx_pop = 1'b0;
    logic [31:0] ser_tx_data;
    logic        ser_rx_push = 1'b0;
    logic [31:0] ser_rx_data = '0;
    logic        link_en, bclk_master, spec_en, spec_sel, irq;
    logic [5:0]  fmt_ctl;
    logic [7:0]  clk_div;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] tx_q[$];
    logic [31:0] rx_q[$];

    always #(CLK_P/2) clk = ~clk;

    aud_serial_port i_aud_serial_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ser_tx_pop  (ser_tx_pop),
        .ser_tx_data (ser_tx_data),
        .ser_rx_push (ser_rx_push),
        .ser_rx_data (ser_rx_data),
        .link_en     (link_en),
        .bclk_master (bclk_master),
        .spec_en     (spec_en),
        .spec_sel    (spec_sel),
        .fmt_ctl     (fmt_ctl),
        .clk_div     (clk_div),
        .irq         (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic chk_pin(input string req, input logic [31:0] act, input logic [31:0] exp);
        @(negedge clk);
        #1 check(req, act, exp);
    endtask

    // Driver: host writes a transmit word; the model keeps at most 16.
    task automatic tx_drive(input logic [31:0] d);
        wr(A_DATA, d);
        if (tx_q.size() < 16) tx_q.push_back(d);
    endtask

    // Monitor: serializer takes a transmit word and compares it.
    task automatic tx_take(input string req);
        logic [31:0] e;
        @(negedge clk);
        ser_tx_pop = 1'b1;
        e = (tx_q.size() > 0) ? tx_q.pop_front() : 32'h0;
        #1 check(req, ser_tx_data, e);
        @(negedge clk);
        ser_tx_pop = 1'b0;
    endtask

    // Driver: serializer delivers a receive word.
    task automatic rx_drive(input logic [31:0] d);
        @(negedge clk);
        ser_rx_push = 1'b1; ser_rx_data = d;
        @(negedge clk);
        ser_rx_push = 1'b0;
        if (rx_q.size() < 16) rx_q.push_back(d);
    endtask

    // Monitor: host reads the data port and compares.
    task automatic rx_take(input string req);
        logic [31:0] v, e;
        e = (rx_q.size() > 0) ? rx_q.pop_front() : 32'h0;
        rd(A_DATA, v);
        check(req, v, e);
    endtask

    initial begin : watchdog
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] v;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_reg("R1 status", A_STAT, 32'h81);
        chk_reg("R1 ctrl", A_CTRL, 32'h0);
        chk_reg("R1 mask", A_MASK, 32'h0);
        chk_reg("R1 div", A_DIV, 32'h0);
        chk_pin("R1 irq", {31'b0, irq}, 32'h0);

        // R2 register fields and pins
        wr(A_CTRL, 32'hABCD_E1F7);
        chk_reg("R2 ctrl readback", A_CTRL, 32'h0000_E135);
        chk_pin("R2 ctrl pins", {28'b0, link_en, bclk_master, spec_en, spec_sel}, 32'hF);
        wr(A_FMT, 32'hFFFF_FFFF);
        chk_reg("R2 fmt readback", A_FMT, 32'h39);
        chk_pin("R2 fmt pins", {26'b0, fmt_ctl}, 32'h39);
        wr(A_MASK, 32'hFFFF_FFFF);
        chk_reg("R2 mask readback", A_MASK, 32'h78);
        wr(A_MASK, 32'h0);
        wr(A_DIV, 32'h0000_1234);
        chk_reg("R2 div readback", A_DIV, 32'h34);
        chk_pin("R2 div pins", {24'b0, clk_div}, 32'h34);
        chk_reg("R11 status idle enabled", A_STAT, 32'h09);

        // R12 unmapped address
        chk_reg("R12 unmapped read", 8'h40, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        chk_reg("R12 unmapped write ctrl", A_CTRL, 32'h0000_E135);
        chk_reg("R12 unmapped write status", A_STAT, 32'h09);

        // R3/R5 transmit path and level boundary (level 1)
        tx_drive(32'h1111_0001);
        chk_reg("R5 tx at level", A_STAT, 32'h0D);
        tx_drive(32'h1111_0002);
        chk_reg("R5 tx above level", A_STAT, 32'h05);
        tx_drive(32'h1111_0003);
        for (int i = 0; i < 3; i++) tx_take("R3 tx order");
        for (int i = 0; i < 17; i++) tx_drive(32'hA000_0000 + i);
        chk_reg("R11 tx full status", A_STAT, 32'h04);
        for (int i = 0; i < 16; i++) tx_take("R3 tx full drain");
        chk_reg("R3 tx drained", A_STAT, 32'h09);

        // R7 underrun and R9 interrupt masking
        tx_take("R7 underrun data zero");
        chk_reg("R7 underrun flag", A_STAT, 32'h29);
        chk_pin("R9 irq masked off", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h20);
        chk_pin("R9 irq underrun", {31'b0, irq}, 32'h1);
        wr(A_MASK, 32'h08);
        chk_pin("R9 irq tx request", {31'b0, irq}, 32'h1);
        wr(A_MASK, 32'h50);
        chk_pin("R9 irq unrelated mask", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h0);

        // R8 write-one-to-clear
        wr(A_CLR, 32'h40);
        chk_reg("R8 other bit no effect", A_STAT, 32'h29);
        wr(A_CLR, 32'h20);
        chk_reg("R8 underrun cleared", A_STAT, 32'h09);

        // R7 underrun with same-cycle host push
        @(negedge clk);
        ser_tx_pop = 1'b1; bus_addr = A_DATA; bus_wdata = 32'hD00D_F00D; bus_wr = 1'b1;
        #1 check("R7 concurrent underrun zero", ser_tx_data, 32'h0);
        @(negedge clk);
        ser_tx_pop = 1'b0; bus_wr = 1'b0;
        tx_q.push_back(32'hD00D_F00D);
        chk_reg("R7 concurrent push kept", A_STAT, 32'h2D);
        tx_take("R7 concurrent word");
        chk_reg("R7 flag remains", A_STAT, 32'h29);

        // R8 new underrun beats same-cycle clear
        @(negedge clk);
        ser_tx_pop = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h20; bus_wr = 1'b1;
        @(negedge clk);
        ser_tx_pop = 1'b0; bus_wr = 1'b0;
        chk_reg("R8 event wins over clear", A_STAT, 32'h29);
        wr(A_CLR, 32'h20);

        // R4 receive path
        rx_drive(32'h2222_0001);
        rx_drive(32'h2222_0002);
        rx_drive(32'h2222_0003);
        chk_reg("R11 rx not empty", A_STAT, 32'h0B);
        for (int i = 0; i < 3; i++) rx_take("R4 rx order");
        rx_take("R4 empty read zero");
        chk_reg("R4 empty read no change", A_STAT, 32'h09);

        // R5 receive level boundary (level 14) and R6 overrun
        for (int i = 0; i < 13; i++) rx_drive(32'hB000_0000 + i);
        chk_reg("R5 rx below level", A_STAT, 32'h0B);
        rx_drive(32'hB000_000D);
        chk_reg("R5 rx at level", A_STAT, 32'h1B);
        rx_drive(32'hB000_000E);
        rx_drive(32'hB000_000F);
        chk_reg("R5 rx full", A_STAT, 32'h1B);
        rx_drive(32'hDEAD_BEEF);
        chk_reg("R6 overrun flag", A_STAT, 32'h5B);
        wr(A_MASK, 32'h40);
        chk_pin("R9 irq overrun", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h40);
        chk_reg("R8 overrun cleared", A_STAT, 32'h1B);
        chk_pin("R9 irq after clear", {31'b0, irq}, 32'h0);

        // R6 push and pop together at full
        @(negedge clk);
        ser_rx_push = 1'b1; ser_rx_data = 32'hC0DE_0001;
        bus_addr = A_DATA; bus_rd = 1'b1;
        e = rx_q.pop_front();
        #1 v = bus_rdata;
        check("R6 concurrent pop data", v, e);
        @(negedge clk);
        ser_rx_push = 1'b0; bus_rd = 1'b0;
        rx_q.push_back(32'hC0DE_0001);
        chk_reg("R6 concurrent no overrun", A_STAT, 32'h1B);
        wr(A_MASK, 32'h10);
        chk_pin("R9 irq rx request", {31'b0, irq}, 32'h1);
        wr(A_MASK, 32'h0);
        for (int i = 0; i < 16; i++) rx_take("R6 rx drain order");
        chk_reg("R4 rx drained", A_STAT, 32'h09);

        // R10 soft reset with content everywhere
        tx_drive(32'h3333_0001);
        tx_drive(32'h3333_0002);
        rx_drive(32'h4444_0001);
        wr(A_MASK, 32'h78);
        wr(A_FMT, 32'h39);
        wr(A_CTRL, 32'h0000_E13D);
        tx_q.delete();
        rx_q.delete();
        chk_reg("R10 ctrl cleared", A_CTRL, 32'h0);
        chk_reg("R10 fmt cleared", A_FMT, 32'h0);
        chk_reg("R10 mask cleared", A_MASK, 32'h0);
        chk_reg("R10 div cleared", A_DIV, 32'h0);
        chk_reg("R10 status default", A_STAT, 32'h81);
        chk_pin("R10 tx emptied", ser_tx_data, 32'h0);
        chk_pin("R10 pins", {26'b0, link_en, bclk_master, spec_en, spec_sel, irq, 1'b0}, 32'h0);
        rx_take("R10 rx emptied");
        chk_reg("R11 link off status", A_STAT, 32'h81);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule